// File: doc/BRIEF.md
# Predicated Integer ALU with Condition Flags

This block executes one integer data-processing operation per clock. It takes a first operand, a second operand that an upstream shifter has already prepared, the shifter's carry-out, the current NZCV flags, a 4-bit opcode, a 4-bit condition code and a flag-update bit. It returns the result, a register write enable and the flag value to hold for the next operation. All three outputs are registered, so they appear one clock after the inputs.

The condition code is tested against the incoming flags before anything else. A failed test turns the operation into a bubble: the write enable stays low and the flags pass through unchanged. The four compare and test operations never produce a write, and they update the flags whenever their condition passes. Every other operation touches the flags only when the update bit is set. The register file, the shifter and memory access sit outside this block.

Top module: `cond_alu`

## Requirements
- R1: The arithmetic opcodes compute their results modulo 2^WIDTH as follows: ADD=4 gives a+b, ADC=5 gives a+b+C, SUB=2 gives a-b, SBC=6 gives a-b+C-1, RSB=3 gives b-a and RSC=7 gives b-a+C-1. C is the incoming carry flag, flags_i[1].
- R2: The bitwise opcodes give these results: AND=0 gives a&b, EOR=1 gives a^b, ORR=12 gives a|b and BIC=14 gives a&~b. The move opcodes MOV=13 (b) and MVN=15 (~b) ignore a.
- R3: TST=8 (a&b), TEQ=9 (a^b), CMP=10 (a-b) and CMN=11 (a+b) never assert wr_en_o. When their condition passes, they always update the flags, whatever set_flags_i is.
- R4: For all opcodes other than 8 to 11, flags_o equals flags_i when set_flags_i is 0. When set_flags_i is 1 and the condition passes, flags_o takes the computed flags.
- R5: The flags are ordered flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V. N is the result MSB and Z is set when the result is all zeros. For arithmetic operations, C is the adder carry-out, so a subtraction sets C when no borrow occurs. V is set on signed overflow. For example, all-ones plus 1 gives NZCV 0110, and the largest positive value plus 1 gives 1001.
- R6: For the bitwise, move and test operations, C takes shift_carry_i and V keeps flags_i[0].
- R7: Conditions 0 to 7 pass as follows: 0 when Z, 1 when !Z, 2 when C, 3 when !C, 4 when N, 5 when !N, 6 when V, 7 when !V.
- R8: Conditions 8 to 13 pass as follows: 8 when C&!Z, 9 when !C|Z, 10 when N==V, 11 when N!=V, 12 when !Z&(N==V), 13 when Z|(N!=V).
- R9: Condition 14 always passes. Condition 15 never passes.
- R10: When the condition fails, wr_en_o is 0 and flags_o equals flags_i.
- R11: Outputs are registered with one cycle of latency. While rst_ni is low, result_o, wr_en_o and flags_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand, already shifted |
| shift_carry_i | input | 1 | Carry-out from the shifter |
| flags_i | input | 4 | Current NZCV flags |
| opcode_i | input | 4 | Operation select |
| cond_i | input | 4 | Condition code |
| set_flags_i | input | 1 | Flag update request for non-compare operations |
| result_o | output | WIDTH | Registered result |
| wr_en_o | output | 1 | Registered register-write enable |
| flags_o | output | 4 | Registered next NZCV flags |

## Verification
Assertions check five properties on every cycle:
- a failed condition produces neither a write nor a flag change;
- compare and test operations never write;
- an operation without the update bit holds the flags;
- bitwise, move and test operations keep V;
- an always-condition non-compare operation writes.

Whether the result values and the computed N, Z, C and V are arithmetically right, and whether each condition code decodes correctly, can only be shown by the bench. It uses a 4-bit configuration and sweeps every opcode against every operand pair, both carry values and both update-bit values, and then sweeps every condition against every flag combination.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // opcodes 8..11 only set flags
  function automatic logic op_is_test(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_alu_pkg::*;
(
  input  nzcv_t      flags_i,
  input  logic [3:0] cond_i,
  output logic       pass_o
);

  logic base;

  // odd codes are the complement of the even code below them; 1111 inverts always
  always_comb begin
    unique case (cond_i[3:1])
      3'd0:    base = flags_i.z;
      3'd1:    base = flags_i.c;
      3'd2:    base = flags_i.n;
      3'd3:    base = flags_i.v;
      3'd4:    base = flags_i.c & ~flags_i.z;
      3'd5:    base = flags_i.n == flags_i.v;
      3'd6:    base = ~flags_i.z & (flags_i.n == flags_i.v);
      default: base = 1'b1;
    endcase
  end

  assign pass_o = base ^ cond_i[0];

endmodule

// File: rtl/alu_core.sv
module alu_core
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e            op_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               c_in_i,
  input  logic               v_in_i,
  input  logic               shift_carry_i,
  output logic [WIDTH-1:0]   res_o,
  output nzcv_t              flags_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin, arith;
  logic [WIDTH:0]   sum;

  always_comb begin
    x = a_i;
    y = b_i;
    cin = 1'b0;
    arith = 1'b1;
    unique case (op_i)
      OP_ADD, OP_CMN: ;
      OP_ADC:         cin = c_in_i;
      OP_SUB, OP_CMP: begin y = ~b_i; cin = 1'b1; end
      OP_SBC:         begin y = ~b_i; cin = c_in_i; end
      OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_RSC:         begin x = b_i; y = ~a_i; cin = c_in_i; end
      default:        arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = sum[MSB:0];
    endcase
  end

  always_comb begin
    flags_o.n = res_o[MSB];
    flags_o.z = ~|res_o;
    flags_o.c = arith ? sum[WIDTH] : shift_carry_i;
    flags_o.v = arith ? ((x[MSB] == y[MSB]) && (sum[MSB] != x[MSB])) : v_in_i;
  end

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             shift_carry_i,
  input  logic [3:0]       flags_i,
  input  logic [3:0]       opcode_i,
  input  logic [3:0]       cond_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);

  alu_op_e          op;
  nzcv_t            cur_flags, calc_flags;
  logic [WIDTH-1:0] calc_res;
  logic             pass, is_test, do_write, do_update;

  assign op        = alu_op_e'(opcode_i);
  assign cur_flags = nzcv_t'(flags_i);
  assign is_test   = op_is_test(op);

  cond_eval u_cond (
    .flags_i (cur_flags),
    .cond_i  (cond_i),
    .pass_o  (pass)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .op_i          (op),
    .a_i           (op_a_i),
    .b_i           (op_b_i),
    .c_in_i        (cur_flags.c),
    .v_in_i        (cur_flags.v),
    .shift_carry_i (shift_carry_i),
    .res_o         (calc_res),
    .flags_o       (calc_flags)
  );

  assign do_write  = pass & ~is_test;
  assign do_update = pass & (is_test | set_flags_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      result_o <= calc_res;
      wr_en_o  <= do_write;
      flags_o  <= do_update ? calc_flags : flags_i;
    end
  end

  // R10: failed condition is a bubble
  a_r10_fail_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass |=> !wr_en_o);
  a_r10_fail_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass |=> flags_o == $past(flags_i));
  // R3: compare/test never writes
  a_r3_test_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i[3:2] == 2'b10) |=> !wr_en_o);
  // R4: no update bit on non-compare holds flags
  a_r4_no_s_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_flags_i && opcode_i[3:2] != 2'b10) |=> flags_o == $past(flags_i));
  // R6: bitwise, move and test ops keep V
  a_r6_logic_v_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15})
      |=> flags_o[0] == $past(flags_i[0]));
  // R9: always-condition writes for non-compare
  a_r9_al_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hE && opcode_i[3:2] != 2'b10) |=> wr_en_o);

endmodule

// File: tb/cond_alu_test.sv
module cond_alu_test;

  localparam int W = 4;
  localparam int M = 1 << W;
  localparam int H = M / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         shc = 1'b0;
  logic [3:0]   fin = '0, opc = '0, cnd = 4'hE;
  logic         sbit = 1'b0;
  logic [W-1:0] res;
  logic         we;
  logic [3:0]   fout;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  cond_alu #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b),
    .shift_carry_i(shc), .flags_i(fin), .opcode_i(opc), .cond_i(cnd),
    .set_flags_i(sbit), .result_o(res), .wr_en_o(we), .flags_o(fout)
  );

  function automatic bit cond_ok(int c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;           1: return !z;
      2: return cy;          3: return !cy;
      4: return n;           5: return !n;
      6: return v;           7: return !v;
      8: return cy && !z;    9: return !cy || z;
      10: return n == v;     11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int sgn(int x);
    return (x >= H) ? x - M : x;
  endfunction

  // returns {we, flags[3:0], result[W-1:0]}
  function automatic logic [W+4:0] model(int op, int av, int bv, bit s,
                                         logic [3:0] f, bit sc, int c);
    int full = 0, sf = 0, r;
    bit ar = 1, addf = 1, cf, vf, tst, pass, upd;
    logic [3:0] nf;
    int cc = f[1];
    case (op)
      4, 11: begin full = av + bv; sf = sgn(av) + sgn(bv); end
      5: begin full = av + bv + cc; sf = sgn(av) + sgn(bv) + cc; end
      2, 10: begin full = av - bv; sf = sgn(av) - sgn(bv); addf = 0; end
      6: begin full = av - bv + cc - 1; sf = sgn(av) - sgn(bv) + cc - 1; addf = 0; end
      3: begin full = bv - av; sf = sgn(bv) - sgn(av); addf = 0; end
      7: begin full = bv - av + cc - 1; sf = sgn(bv) - sgn(av) + cc - 1; addf = 0; end
      default: ar = 0;
    endcase
    if (ar) begin
      r = full & (M - 1);
      cf = addf ? (full >= M) : (full >= 0);
      vf = (sf >= H) || (sf < -H);
    end else begin
      case (op)
        0, 8: r = av & bv;
        1, 9: r = av ^ bv;
        12: r = av | bv;
        13: r = bv;
        14: r = av & ~bv;
        default: r = ~bv;
      endcase
      r = r & (M - 1);
      cf = sc;
      vf = f[0];
    end
    tst = (op >= 8) && (op <= 11);
    pass = cond_ok(c, f);
    upd = pass && (tst || s);
    nf = upd ? {r >= H, r == 0, cf, vf} : f;
    return {pass && !tst, nf, W'(r)};
  endfunction

  task automatic check(string tag, logic [W+4:0] exp);
    checks++;
    if ({we, fout, res} !== exp) begin
      fails++;
      $display("FAIL %s: got we=%b nzcv=%b res=%h, expected we=%b nzcv=%b res=%h",
               tag, we, fout, res, exp[W+4], exp[W+3:W], exp[W-1:0]);
    end
  endtask

  task automatic run(int op, int av, int bv, bit s, logic [3:0] f, bit sc, int c,
                     string tag);
    @(negedge clk);
    opc = 4'(op); a = W'(av); b = W'(bv); sbit = s; fin = f; shc = sc; cnd = 4'(c);
    @(negedge clk);
    check(tag, model(op, av, bv, s, f, sc, c));
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11 reset", '0);
    rst_n = 1'b1;

    // opcode sweep under the always condition
    for (int op = 0; op < 16; op++) begin
      if (op >= 8 && op <= 11) tag = "R3 R5 R6";
      else if (op inside {2, 3, 4, 5, 6, 7}) tag = "R1 R5";
      else tag = "R2 R6";
      for (int av = 0; av < M; av++)
        for (int bv = 0; bv < M; bv++)
          for (int ci = 0; ci < 2; ci++)
            for (int s = 0; s < 2; s++) begin
              logic [3:0] f;
              f = {av[0] ^ bv[1], bv[0], ci[0], av[1] ^ bv[2]};
              run(op, av, bv, s[0], f, av[2] ^ bv[0],
                  14, (s == 0 && !(op >= 8 && op <= 11)) ? "R4" : tag);
            end
    end

    // R5 examples: all ones + 1, max positive + 1
    run(4, M - 1, 1, 1, 4'b0000, 0, 14, "R5 wrap");
    run(4, H - 1, 1, 1, 4'b0000, 0, 14, "R5 overflow");

    // condition sweep with an updating add and a compare
    for (int c = 0; c < 16; c++) begin
      if (c < 8) tag = "R7 R10";
      else if (c < 14) tag = "R8 R10";
      else tag = "R9 R10";
      for (int f = 0; f < 16; f++) begin
        run(4, 3, 4, 1, 4'(f), 1, c, tag);
        run(10, 5, 5, 0, 4'(f), 0, c, tag);
        run(13, 9, M - 1, 1, 4'(f), 1, c, tag);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule